// File: doc/BRIEF.md
# Trace Capture Window Filter

This block sits in front of a trace buffer and decides, in the same cycle that an entry is offered, whether that entry may be stored. Recording happens inside a window that opens and closes on two kinds of trigger. The first kind comes from a 64-line debug event bus, with a start mask and an end mask over the lines. The second kind comes from the 16-bit tag carried by each entry, through a masked compare against a start reference and an end reference. Each source of entries (a link) has its own enable bit, and a global enable gates everything.

Configuration is loaded through a simple register write port with byte enables. The mode bits live in a control word that only accepts a full-width write carrying an unlock key. A combinational read port returns the stored configuration. The block also drives a capture-select bit, which tells the storage side whether each entry carries a timestamp or a program counter. The buffer, the timestamp counter and the bus fabric are outside this block.

Top module: `trace_window_filter`

## Requirements
- R1: After reset the window is closed, every configuration word reads 0, and recordAllow and captureSelPc are 0.
- R2: While the global enable (control bit 0) is 0, recordAllow stays 0, and no event line or tag changes the window state.
- R3: An entry whose link field is n (4 bits) can only be allowed when bit n of the link-enable word (address 9) is 1.
- R4: With the global enable set and both filters off (control bits 1 and 2 clear), the window counts as open and every link-enabled valid entry is allowed.
- R5: With event filtering on (control bit 1), any asserted event line whose start-mask bit is set opens the window. Lines 0-31 are masked by address 1 and lines 32-63 by address 2.
- R6: With event filtering on, any asserted event line whose end-mask bit is set closes the window. Lines 0-31 are masked by address 3 and lines 32-63 by address 4.
- R7: With tag filtering on (control bit 2), a valid entry whose tag ANDed with the start mask (address 6) equals the start reference (address 5) opens the window. A tag presented without entryValid has no effect.
- R8: With tag filtering on, a valid entry whose tag ANDed with the end mask (address 8) equals the end reference (address 7) closes the window.
- R9: When a start condition and an end condition occur in the same cycle, the end wins and the window is closed afterwards.
- R10: With both filters on, either source may open or close the one shared window.
- R11: The gating for an entry uses the window state that results from its own cycle. The entry that opens the window is allowed, and the entry on a closing cycle is not.
- R12: The control word (address 0) changes only on a write with all four byte enables set and bits 31:16 equal to 0x5A5A. Any other write to it is ignored, and bits 31:16 always read as 0.
- R13: Writing control bit 4 as 1 in a keyed write closes the window from the next cycle, and bit 4 reads back as 0.
- R14: captureSelPc follows control bit 3 (0 selects a timestamp, 1 selects the program counter) from the cycle after the keyed write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register word address |
| wrByteEn | input | 4 | Byte enables of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 32 | Read data (combinational) |
| evtLines | input | 64 | Debug event lines |
| entryValid | input | 1 | A trace entry is offered this cycle |
| entryLink | input | 4 | Link number of the entry |
| entryTag | input | 16 | Tag of the entry |
| recordAllow | output | 1 | The offered entry may be stored |
| captureSelPc | output | 1 | 1: store program counter, 0: store timestamp |
| windowOpen | output | 1 | Registered recording-window state |

## Verification
The bench tries a control write with a wrong key and a write with a correct key but partial byte enables. A design that ignored the key or the byte enables would change the mode bits on either write. It places start and end on the same cycle. A design that let start win would leave the window open. It also gates the very entry that opens or closes the window, which shows whether the filter uses the current-cycle state or the stale one. It triggers from the upper half of the event bus and from tag sources in both filter modes, which exposes a half-word mapping error or a filter source ignored when both are on. A tag presented without entryValid, and events seen while globally disabled, must leave the window untouched.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int EVT_LINES = 64;
  localparam int TAG_W = 16;
  localparam int LINK_CNT = 16;
  localparam int LINK_W = $clog2(LINK_CNT);
  localparam int DATA_W = 32;
  localparam int BYTES = DATA_W / 8;
  localparam int EVT_WORDS = EVT_LINES / DATA_W;
  localparam logic [15:0] UNLOCK_KEY = 16'h5A5A;

  // word map
  localparam int W_CTRL = 0;
  localparam int W_EVS = 1;
  localparam int W_EVE = W_EVS + EVT_WORDS;
  localparam int W_TSR = W_EVE + EVT_WORDS;
  localparam int W_TSM = W_TSR + 1;
  localparam int W_TER = W_TSM + 1;
  localparam int W_TEM = W_TER + 1;
  localparam int W_LNK = W_TEM + 1;
  localparam int NUM_WORDS = W_LNK + 1;
  localparam int ADDR_W = $clog2(NUM_WORDS);
  localparam int WORDS_PAD = 1 << ADDR_W;

  // control word bit positions
  localparam int CB_GLOBAL = 0;
  localparam int CB_EVT = 1;
  localparam int CB_TAG = 2;
  localparam int CB_CAP = 3;
  localparam int CB_FRST = 4;
  localparam int CTRL_KEEP = 4;

  typedef struct packed {
    logic globalEn;
    logic evtFilterEn;
    logic tagFilterEn;
    logic [EVT_LINES-1:0] evtStart;
    logic [EVT_LINES-1:0] evtEnd;
    logic [TAG_W-1:0] tagStartRef;
    logic [TAG_W-1:0] tagStartMask;
    logic [TAG_W-1:0] tagEndRef;
    logic [TAG_W-1:0] tagEndMask;
    logic [LINK_CNT-1:0] linkEn;
  } twf_cfg_t;

  typedef struct packed {
    logic clrWindow;
  } twf_strobe_t;

  function automatic logic [DATA_W-1:0] wordMask(int idx);
    if (idx == W_CTRL || idx >= NUM_WORDS) return '0;
    if (idx >= W_TSR && idx <= W_TEM) return DATA_W'((64'd1 << TAG_W) - 1);
    if (idx == W_LNK) return DATA_W'((64'd1 << LINK_CNT) - 1);
    return '1;
  endfunction
endpackage

// File: rtl/twf_ctrl.sv
module twf_ctrl
  import twf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTES-1:0] wrByteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output twf_cfg_t cfg,
  output twf_strobe_t strobe,
  output logic capSelPc
);
  logic ctrlHit;
  logic keyOk;
  logic [CTRL_KEEP-1:0] ctrlBitsQ;
  logic [DATA_W-1:0] words [WORDS_PAD];

  assign ctrlHit = wrEn && (wrAddr == ADDR_W'(W_CTRL));
  assign keyOk = ctrlHit && (&wrByteEn) && (wrData[DATA_W-1:DATA_W-16] == UNLOCK_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlBitsQ <= '0;
    else if (keyOk) ctrlBitsQ <= wrData[CTRL_KEEP-1:0];
  end

  assign strobe.clrWindow = keyOk && wrData[CB_FRST];

  // plain configuration words, one register per implemented word
  for (genvar i = 0; i < WORDS_PAD; i++) begin : g_word
    localparam logic [DATA_W-1:0] M = wordMask(i);
    if (M == '0) begin : g_none
      assign words[i] = '0;
    end else begin : g_reg
      logic [DATA_W-1:0] wordQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) wordQ <= '0;
        else if (wrEn && wrAddr == ADDR_W'(i)) begin
          for (int b = 0; b < BYTES; b++)
            if (wrByteEn[b]) wordQ[b*8 +: 8] <= wrData[b*8 +: 8] & M[b*8 +: 8];
        end
      end
      assign words[i] = wordQ;
    end
  end

  always_comb begin
    cfg = '0;
    cfg.globalEn = ctrlBitsQ[CB_GLOBAL];
    cfg.evtFilterEn = ctrlBitsQ[CB_EVT];
    cfg.tagFilterEn = ctrlBitsQ[CB_TAG];
    for (int w = 0; w < EVT_WORDS; w++) begin
      cfg.evtStart[w*DATA_W +: DATA_W] = words[W_EVS + w];
      cfg.evtEnd[w*DATA_W +: DATA_W] = words[W_EVE + w];
    end
    cfg.tagStartRef = words[W_TSR][TAG_W-1:0];
    cfg.tagStartMask = words[W_TSM][TAG_W-1:0];
    cfg.tagEndRef = words[W_TER][TAG_W-1:0];
    cfg.tagEndMask = words[W_TEM][TAG_W-1:0];
    cfg.linkEn = words[W_LNK][LINK_CNT-1:0];
  end

  assign capSelPc = ctrlBitsQ[CB_CAP];

  always_comb begin
    if (rdAddr == ADDR_W'(W_CTRL)) rdData = DATA_W'(ctrlBitsQ);
    else rdData = words[rdAddr];
  end

  // R12: a control write without the key or full width leaves the mode bits alone
  p_key_guard_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlHit && !keyOk) |=> $stable(ctrlBitsQ));

  // R12: a keyed write loads the mode bits
  p_key_load_r12: assert property (@(posedge clk) disable iff (!rstN)
    keyOk |=> (ctrlBitsQ == $past(wrData[CTRL_KEEP-1:0])));
endmodule

// File: rtl/twf_window.sv
module twf_window
  import twf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  twf_cfg_t cfg,
  input  twf_strobe_t strobe,
  input  logic [EVT_LINES-1:0] evtLines,
  input  logic entryValid,
  input  logic [LINK_W-1:0] entryLink,
  input  logic [TAG_W-1:0] entryTag,
  output logic recordAllow,
  output logic windowOpen
);
  logic windowQ;
  logic windowNext;
  logic evtStart, evtEnd, tagStart, tagEnd;
  logic startHit, endHit;
  logic filterOn;
  logic gate;

  assign evtStart = cfg.evtFilterEn && |(evtLines & cfg.evtStart);
  assign evtEnd = cfg.evtFilterEn && |(evtLines & cfg.evtEnd);
  assign tagStart = cfg.tagFilterEn && entryValid &&
                    ((entryTag & cfg.tagStartMask) == cfg.tagStartRef);
  assign tagEnd = cfg.tagFilterEn && entryValid &&
                  ((entryTag & cfg.tagEndMask) == cfg.tagEndRef);

  assign startHit = cfg.globalEn && (evtStart || tagStart);
  assign endHit = cfg.globalEn && (evtEnd || tagEnd);

  always_comb begin
    if (strobe.clrWindow) windowNext = 1'b0;
    else if (endHit) windowNext = 1'b0;
    else if (startHit) windowNext = 1'b1;
    else windowNext = windowQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) windowQ <= 1'b0;
    else windowQ <= windowNext;
  end

  assign filterOn = cfg.evtFilterEn || cfg.tagFilterEn;
  assign gate = filterOn ? windowNext : 1'b1;
  assign recordAllow = cfg.globalEn && entryValid && cfg.linkEn[entryLink] && gate;
  assign windowOpen = windowQ;

  // R9: an end condition always leaves the window closed
  p_end_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    endHit |=> !windowOpen);

  // R5: a lone start opens the window
  p_start_opens_r5: assert property (@(posedge clk) disable iff (!rstN)
    (startHit && !endHit && !strobe.clrWindow) |=> windowOpen);

  // R13: filter reset closes the window
  p_clear_r13: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrWindow |=> !windowOpen);

  // R2: globally disabled, nothing but a filter reset moves the window
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!cfg.globalEn && !strobe.clrWindow) |=> $stable(windowOpen));
endmodule

// File: rtl/trace_window_filter.sv
module trace_window_filter
  import twf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTES-1:0] wrByteEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [EVT_LINES-1:0] evtLines,
  input  logic entryValid,
  input  logic [LINK_W-1:0] entryLink,
  input  logic [TAG_W-1:0] entryTag,
  output logic recordAllow,
  output logic captureSelPc,
  output logic windowOpen
);
  twf_cfg_t cfg;
  twf_strobe_t strobe;

  twf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrByteEn(wrByteEn), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .cfg(cfg), .strobe(strobe), .capSelPc(captureSelPc)
  );

  twf_window u_window (
    .clk(clk), .rstN(rstN), .cfg(cfg), .strobe(strobe),
    .evtLines(evtLines), .entryValid(entryValid), .entryLink(entryLink),
    .entryTag(entryTag), .recordAllow(recordAllow), .windowOpen(windowOpen)
  );
endmodule

// File: tb/trace_window_filter_tb.sv
module trace_window_filter_tb;
  import twf_pkg::*;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [BYTES-1:0] wrByteEn = '0;
  logic [DATA_W-1:0] wrData = '0;
  logic [ADDR_W-1:0] rdAddr = '0;
  logic [DATA_W-1:0] rdData;
  logic [EVT_LINES-1:0] evtLines = '0;
  logic entryValid = 1'b0;
  logic [LINK_W-1:0] entryLink = '0;
  logic [TAG_W-1:0] entryTag = '0;
  logic recordAllow, captureSelPc, windowOpen;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  trace_window_filter u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrByteEn(wrByteEn),
    .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData), .evtLines(evtLines),
    .entryValid(entryValid), .entryLink(entryLink), .entryTag(entryTag),
    .recordAllow(recordAllow), .captureSelPc(captureSelPc), .windowOpen(windowOpen)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic regWrite(int addr, logic [31:0] data, logic [3:0] be = 4'hF);
    @(negedge clk);
    wrEn = 1'b1; wrAddr = ADDR_W'(addr); wrData = data; wrByteEn = be;
    @(negedge clk);
    wrEn = 1'b0; wrByteEn = '0;
  endtask

  task automatic setCtrl(logic [4:0] bits);
    regWrite(W_CTRL, {UNLOCK_KEY, 11'h0, bits});
  endtask

  task automatic readCheck(string req, int addr, logic [31:0] exp);
    rdAddr = ADDR_W'(addr);
    #1 check(req, rdData, exp);
  endtask

  // one stimulus cycle: check the same-cycle gate, then the new window state
  task automatic step(string req, logic [63:0] evt, logic vld, int link,
                      logic [15:0] tag, logic expAllow, logic expWin);
    @(negedge clk);
    evtLines = evt; entryValid = vld; entryLink = LINK_W'(link); entryTag = tag;
    #1 check({req, " allow"}, recordAllow, expAllow);
    @(negedge clk);
    evtLines = '0; entryValid = 1'b0; entryTag = '0;
    check({req, " window"}, windowOpen, expWin);
  endtask

  task automatic t_reset();
    check("R1 window", windowOpen, 0);
    check("R1 captureSel", captureSelPc, 0);
    entryValid = 1'b1;
    #1 check("R1 allow", recordAllow, 0);
    entryValid = 1'b0;
    for (int a = 0; a < NUM_WORDS; a++) readCheck("R1 config word", a, 0);
  endtask

  task automatic t_key();
    regWrite(W_CTRL, 32'h1234_0001);
    readCheck("R12 wrong key ignored", W_CTRL, 0);
    regWrite(W_CTRL, {UNLOCK_KEY, 16'h0001}, 4'b0011);
    readCheck("R12 partial write ignored", W_CTRL, 0);
    regWrite(W_CTRL, {UNLOCK_KEY, 16'h0001}, 4'b1100);
    readCheck("R12 upper-half write ignored", W_CTRL, 0);
    setCtrl(5'h01);
    readCheck("R12 keyed write, key reads 0", W_CTRL, 32'h0000_0001);
  endtask

  task automatic t_links();
    regWrite(W_LNK, 32'h0000_0004);
    step("R4 no filter link2", '0, 1, 2, 16'h0, 1, 0);
    step("R3 link3 disabled", '0, 1, 3, 16'h0, 0, 0);
    regWrite(W_LNK, 32'h0000_8000);
    step("R3 link15 enabled", '0, 1, 15, 16'h0, 1, 0);
    step("R3 link2 now disabled", '0, 1, 2, 16'h0, 0, 0);
    regWrite(W_LNK, 32'h0000_FFFF);
  endtask

  task automatic t_global_off();
    regWrite(W_EVS, 32'h0000_0020);
    setCtrl(5'h02);
    step("R2 disabled start ignored", 64'h20, 1, 2, 16'h0, 0, 0);
  endtask

  task automatic t_events();
    regWrite(W_EVE + 1, 32'h0000_0100);
    regWrite(W_EVS + 1, 32'h8000_0000);
    setCtrl(5'h03);
    step("R5 closed blocks entry", '0, 1, 1, 16'h0, 0, 0);
    step("R11 opening entry allowed", 64'h20, 1, 1, 16'h0, 1, 1);
    step("R5 open passes entry", '0, 1, 4, 16'h0, 1, 1);
    step("R11 closing entry blocked", 64'd1 << 40, 1, 4, 16'h0, 0, 0);
    step("R6 stays closed", '0, 1, 4, 16'h0, 0, 0);
    step("R5 upper half start", 64'd1 << 63, 0, 0, 16'h0, 0, 1);
    step("R6 end closes", 64'd1 << 40, 0, 0, 16'h0, 0, 0);
  endtask

  task automatic t_priority();
    step("R9 start and end together", 64'h20 | (64'd1 << 40), 1, 0, 16'h0, 0, 0);
    step("R9 reopen", 64'h20, 0, 0, 16'h0, 0, 1);
    step("R9 end wins while open", 64'h20 | (64'd1 << 40), 0, 0, 16'h0, 0, 0);
  endtask

  task automatic t_filter_reset();
    step("R13 open first", 64'h20, 0, 0, 16'h0, 0, 1);
    setCtrl(5'h13);
    check("R13 window cleared", windowOpen, 0);
    readCheck("R13 bit reads 0", W_CTRL, 32'h0000_0003);
  endtask

  task automatic t_tags();
    regWrite(W_TSM, 32'h0000_FF00);
    regWrite(W_TSR, 32'h0000_3A00);
    regWrite(W_TEM, 32'h0000_000F);
    regWrite(W_TER, 32'h0000_0005);
    setCtrl(5'h05);
    step("R7 tag without valid ignored", '0, 0, 0, 16'h3A77, 0, 0);
    step("R7 tag start opens", '0, 1, 6, 16'h3A77, 1, 1);
    step("R7 other tag passes", '0, 1, 6, 16'h1234, 1, 1);
    step("R8 tag end closes", '0, 1, 6, 16'h0005, 0, 0);
    step("R8 events ignored", 64'h20, 0, 0, 16'h0, 0, 0);
  endtask

  task automatic t_both();
    setCtrl(5'h07);
    step("R10 tag opens", '0, 1, 0, 16'h3A77, 1, 1);
    step("R10 event closes", 64'd1 << 40, 0, 0, 16'h0, 0, 0);
    step("R10 event opens", 64'h20, 0, 0, 16'h0, 0, 1);
    step("R10 tag closes", '0, 1, 0, 16'h0005, 0, 0);
  endtask

  task automatic t_capture();
    setCtrl(5'h09);
    check("R14 program counter selected", captureSelPc, 1);
    setCtrl(5'h01);
    check("R14 timestamp selected", captureSelPc, 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_key();
    t_links();
    t_global_off();
    t_events();
    t_priority();
    t_filter_reset();
    t_tags();
    t_both();
    t_capture();
    finishRun();
  end
endmodule